// File: doc/BRIEF.md
# Periodic Reload Tick Timer

This block is a down-counting periodic tick source of the kind placed next to a processor core to give the operating system a steady time base. Software programs a reload value, picks whether the counter advances on every core clock or on every second core clock, and turns counting and the tick request on through a small control register. From then on the counter runs down to zero, reloads itself, and raises a one-cycle interrupt request for each completed period without any acknowledge from the handler.

Three word registers sit on a simple select/write bus: control at index 0, reload at index 1 and current value at index 2. Reads are combinational; the read strobe of the control register also consumes a sticky count flag so that polling software can see whether a period has elapsed since its last look.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read as 0, the count flag is clear and `tick_irq` is low.
- R2: Register index 0 is control (bit 0 run, bit 1 interrupt enable, bit 2 clock source with 1 = core clock and 0 = core clock divided by two, bit 16 count flag), index 1 is reload, index 2 is current value, and index 3 reads as 0; writing 0b111 to control reads back 0b111.
- R3: While running on the core clock, the counter steps down by one per cycle and, at a count of 0, loads the reload value, so ticks repeat every reload+1 core cycles.
- R4: With bit 2 clear, the counter advances only every second core cycle, so ticks repeat every 2×(reload+1) core cycles.
- R5: Each transition of the count from 1 to 0 produces exactly one `tick_irq` pulse, one core cycle wide, with no acknowledge needed before the next.
- R6: `tick_irq` stays low while control bit 1 is 0, although the count flag is still set by each tick.
- R7: The count flag (control bit 16) is set by a 1-to-0 transition and cleared by a read of control; a tick in the same cycle as such a read leaves it set.
- R8: Any write to the current-value register clears the count to 0 and clears the count flag.
- R9: With a reload value of 0 the counter stays at 0 and produces no ticks even while running.
- R10: With control bit 0 clear, the current value does not change.
- R11: Reload holds only 24 bits; write data above bit 23 is dropped and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bound checker watches, on every cycle, that the request is never wider than one cycle and only follows a tick taken while the interrupt enable was set, that a halted or zero-reload counter holds still, that a current-value write leaves count and flag at zero, and that a tick always leaves the flag set. The tick period in both clock-source modes, the register map and field widths, and the read-to-clear behaviour of the flag can only be shown by the bench's scenarios, which time the spacing of requests and read registers back over the bus.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int REG_AW   = 2;
  localparam int FLAG_BIT = 16;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;

  // control fields, packed MSB first: [2]=full-rate clock, [1]=irq enable, [0]=run
  typedef struct packed {
    logic clk_full;
    logic irq_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tick_prescale.sv
// Produces the count strobe: every cycle on the full-rate source,
// every second cycle on the halved source.
module tick_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clk_full,
  output logic count_pulse
);
  logic half_phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_phase_q <= 1'b0;
    else        half_phase_q <= ~half_phase_q;
  end

  always_comb count_pulse = run && (clk_full || half_phase_q);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_pulse,
  input  logic             cur_clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             tick_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rl
  );
    return (cur == '0) ? rl : cur - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cur_clr)     cnt_q <= '0;
    else if (count_pulse) cnt_q <= step_count(cnt_q, reload);
  end

  always_comb begin
    cnt      = cnt_q;
    tick_evt = count_pulse && !cur_clr && (cnt_q == ONE);
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick_evt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic              flag
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             wr_ctrl, wr_reload, rd_ctrl;

  always_comb begin
    wr_ctrl   = bus_sel &&  bus_wr && (bus_addr == REG_CTRL);
    wr_reload = bus_sel &&  bus_wr && (bus_addr == REG_RELOAD);
    cur_clr   = bus_sel &&  bus_wr && (bus_addr == REG_CURRENT);
    rd_ctrl   = bus_sel && !bus_wr && (bus_addr == REG_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // clear by current write, set by tick (wins over read), clear by read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (cur_clr)  flag_q <= 1'b0;
    else if (tick_evt) flag_q <= 1'b1;
    else if (rd_ctrl)  flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[CTRL_W-1:0] = ctrl_q;
        bus_rdata[FLAG_BIT]   = flag_q;
      end
      REG_RELOAD:  bus_rdata[CNT_W-1:0] = reload_q;
      REG_CURRENT: bus_rdata[CNT_W-1:0] = cnt;
      default:     bus_rdata = '0;
    endcase
  end

  always_comb begin
    ctrl   = ctrl_q;
    reload = reload_q;
    flag   = flag_q;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_clr;
  logic             flag_q;
  logic             count_pulse;
  logic             tick_evt;
  logic             irq_q;

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .tick_evt  (tick_evt),
    .ctrl      (ctrl_q),
    .reload    (reload_q),
    .cur_clr   (cur_clr),
    .flag      (flag_q)
  );

  tick_prescale prescale_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (ctrl_q.run),
    .clk_full    (ctrl_q.clk_full),
    .count_pulse (count_pulse)
  );

  tick_counter #(.CNT_W(CNT_W)) counter_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_pulse (count_pulse),
    .cur_clr     (cur_clr),
    .reload      (reload_q),
    .cnt         (cnt_q),
    .tick_evt    (tick_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= tick_evt && ctrl_q.irq_en;
  end

  always_comb tick_irq = irq_q;
endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             tick_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             run,
  input logic             irq_en,
  input logic             cur_clr,
  input logic             flag
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick_evt) && $past(irq_en))); // R6

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cur_clr) |=> $stable(cnt)); // R10

  AST_ZERO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && reload == '0) |=> (cnt == '0)); // R9

  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_clr |=> (cnt == '0 && !flag)); // R8

  AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> flag); // R7
endmodule

bind core_tick_timer core_tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (tick_irq),
  .tick_evt (tick_evt),
  .cnt      (cnt_q),
  .reload   (reload_q),
  .run      (ctrl_q.run),
  .irq_en   (ctrl_q.irq_en),
  .cur_clr  (cur_clr),
  .flag     (flag_q)
);

// File: tb/core_tick_timer_tb_top.sv
module core_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  core_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // stop, zero the counter, program and start
  task automatic start(input logic [31:0] rl, input logic [2:0] ctl);
    bus_write(2'd0, 32'd0);
    bus_write(2'd1, rl);
    bus_write(2'd2, 32'd0);
    bus_write(2'd0, {29'd0, ctl});
  endtask

  // count irq pulses over n cycles, sampled at negedge
  task automatic count_irqs(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_irq) cnt++;
    end
  endtask

  // spacing between two pulses and width of the first one
  task automatic measure(output int period, output int width);
    int guard;
    guard = 0;
    period = -1; width = 0;
    do begin @(negedge clk); guard++; end while (!tick_irq && guard < 2000);
    if (!tick_irq) return;
    while (tick_irq) begin width++; @(negedge clk); end
    period = width;
    guard = 0;
    while (!tick_irq && guard < 2000) begin period++; @(negedge clk); guard++; end
    if (!tick_irq) period = -1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", {31'd0, tick_irq}, 32'd0);
    bus_read(2'd0, d); check("R1 control after reset", d, 32'd0);
    bus_read(2'd1, d); check("R1 reload after reset", d, 32'd0);
    bus_read(2'd2, d); check("R1 current after reset", d, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    bus_write(2'd0, 32'h7);
    bus_read(2'd0, d); check("R2 control readback", d, 32'h7);
    bus_read(2'd3, d); check("R2 spare index reads 0", d, 32'd0);
    bus_write(2'd0, 32'd0);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, d); check("R11 reload 24-bit field", d, 32'h00FF_FFFF);
  endtask

  task automatic t_period_full(input int rl);
    int p, w;
    start(rl, 3'b111);
    measure(p, w);
    check("R3 full-rate period", p, rl + 1);
    check("R5 pulse width", w, 1);
    measure(p, w);
    check("R5 repeat without acknowledge", p, rl + 1);
  endtask

  task automatic t_period_half(input int rl);
    int p, w;
    start(rl, 3'b011);
    measure(p, w);
    check("R4 halved-source period", p, 2 * (rl + 1));
    check("R5 pulse width halved source", w, 1);
  endtask

  task automatic t_gated_and_flag;
    int n;
    logic [31:0] d;
    start(5, 3'b101);
    count_irqs(40, n);
    check("R6 no irq while bit1 clear", n, 0);
    bus_write(2'd0, 32'h4);
    bus_read(2'd0, d); check("R7 flag set by tick", d[16], 1'b1);
    bus_read(2'd0, d); check("R7 flag cleared by read", d[16], 1'b0);
  endtask

  task automatic t_cur_clear;
    logic [31:0] d;
    start(7, 3'b101);
    count_irqs(20, d);
    bus_write(2'd0, 32'h4);
    bus_write(2'd2, 32'h1234);
    bus_read(2'd2, d); check("R8 current cleared by write", d, 32'd0);
    bus_read(2'd0, d); check("R8 flag cleared by current write", d[16], 1'b0);
  endtask

  task automatic t_halt;
    logic [31:0] a, b;
    start(100, 3'b101);
    count_irqs(10, a);
    bus_write(2'd0, 32'h4);
    bus_read(2'd2, a);
    count_irqs(20, b);
    bus_read(2'd2, b);
    check("R10 current frozen when halted", b, a);
    check("R10 current was mid-count", {31'd0, a != 0}, 32'd1);
  endtask

  task automatic t_zero_reload;
    int n;
    logic [31:0] d;
    start(0, 3'b111);
    count_irqs(60, n);
    check("R9 zero reload gives no ticks", n, 0);
    bus_read(2'd2, d); check("R9 current stays 0", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_period_full(3);
    t_period_full(1);
    t_period_full(17);
    t_period_half(3);
    t_period_half(10);
    t_gated_and_flag;
    t_cur_clear;
    t_halt;
    t_zero_reload;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule